// File: doc/BRIEF.md
# Message Doorbell to Interrupt-Line Frame

This block lets a device raise a wired interrupt by writing a single word. It sits on a 32-bit register port and owns a contiguous range of shared peripheral interrupt lines, set by two parameters: the first line's number (`BASE_SPI`) and the number of lines (`NUM_SPI`). When a doorbell write carries an interrupt ID inside the frame's range, the matching output line goes high for exactly one clock. Each output feeds an edge-configured input of the interrupt distributor, so every write counts as one event. The ID is absolute: it equals the line number plus 32.

A read-only descriptor word reports the range so software can find it. An ID outside the range produces no pulse. It sets a sticky error bit that software can read back, and only reset clears that bit. The port takes one access per cycle, and `req_ready` is always high.

The response path is a two-state machine. `ST_IDLE` means no read data is on the port. `ST_RD_RESP` means read data is on the port this cycle. An accepted read moves the machine to `ST_RD_RESP` from either state. Any other cycle moves it to `ST_IDLE`. This allows back-to-back reads to stay in `ST_RD_RESP`.

Top module: `msg_doorbell_frame`

## Requirements
- R1: A read of offset 0x008 returns the first line number in bits [25:16] and the line count in bits [9:0], with all other bits zero. With the default parameters (64, 16) the word is 0x00400010.
- R2: A write to offset 0x040 whose full 32-bit data lies in [BASE_SPI+32, BASE_SPI+32+NUM_SPI-1] drives `irq_pulse[data-BASE_SPI-32]` high. The pulse appears in the cycle after the access is accepted and lasts exactly one cycle. No other line moves.
- R3: Doorbell writes accepted in consecutive cycles produce one pulse each, in consecutive cycles, on their own lines.
- R4: A doorbell write with data outside that range produces no pulse and sets the error bit. The error bit is bit 0 of the word read at offset 0x010. It stays set until reset.
- R5: A read of the doorbell offset returns zero, and a read of any unmapped offset returns zero.
- R6: A write to the descriptor offset 0x008 has no effect: no pulse, and the descriptor reads back unchanged.
- R7: `req_ready` is always high. Each accepted read gives `rsp_valid` high for one cycle, in the following cycle, with the data. Writes give no response.
- R8: After reset, all pulse lines and `rsp_valid` are low and the error bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Access accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_wdata | input | 32 | Write data (interrupt ID for the doorbell) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_pulse | output | NUM_SPI | One-cycle pulses, bit i for line BASE_SPI+i |

## Verification
A wrong range or offset computation shows up one cycle after a doorbell write. The pulse lands on a neighbouring bit, appears for an ID one past either end of the range, or fails to appear. A stuck or lost error bit is invisible until the next read of offset 0x010, so the checks read it both before and after the out-of-range writes. A response-state fault shows on `rsp_valid` in the cycle directly after the access. Back-to-back writes and reads expose a state machine that loses an access.

// File: rtl/msgdb_pkg.sv
package msgdb_pkg;
    localparam int unsigned  SPI_ID_OFS   = 32;
    localparam logic [11:0]  OFS_DESC     = 12'h008;
    localparam logic [11:0]  OFS_ERR      = 12'h010;
    localparam logic [11:0]  OFS_DOORBELL = 12'h040;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RD_RESP = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/msgdb_decode.sv
module msgdb_decode
    import msgdb_pkg::*;
#(
    parameter int unsigned BASE_SPI = 64,
    parameter int unsigned NUM_SPI  = 16,
    parameter int unsigned LINE_W   = 4
) (
    input  logic              db_wr_i,
    input  logic [31:0]       id_i,
    output logic              hit_o,
    output logic              miss_o,
    output logic [LINE_W-1:0] line_o
);
    localparam logic [31:0] ID_LO = 32'(BASE_SPI + SPI_ID_OFS);
    localparam logic [31:0] ID_HI = 32'(BASE_SPI + SPI_ID_OFS + NUM_SPI - 1);

    logic in_range;

    always_comb begin
        in_range = (id_i >= ID_LO) && (id_i <= ID_HI);
        hit_o    = db_wr_i && in_range;
        miss_o   = db_wr_i && !in_range;
        line_o   = LINE_W'(id_i - ID_LO);
    end
endmodule

// File: rtl/msgdb_pulse.sv
module msgdb_pulse #(
    parameter int unsigned NUM_SPI = 16,
    parameter int unsigned LINE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_i,
    input  logic [LINE_W-1:0]  line_i,
    output logic [NUM_SPI-1:0] pulse_o
);
    logic [NUM_SPI-1:0] pulse_q;

    for (genvar g = 0; g < NUM_SPI; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) pulse_q[g] <= 1'b0;
            else        pulse_q[g] <= fire_i && (line_i == LINE_W'(g));
        end
    end

    assign pulse_o = pulse_q;

    // R2
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_q) |-> $past(fire_i));

    // R2
    pulse_single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> ($countones(pulse_q) == 1));
endmodule

// File: rtl/msgdb_regs.sv
module msgdb_regs
    import msgdb_pkg::*;
#(
    parameter int unsigned BASE_SPI = 64,
    parameter int unsigned NUM_SPI  = 16,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              db_miss_i,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_rdata_o
);
    localparam logic [31:0] DESC_WORD = {6'd0, 10'(BASE_SPI), 6'd0, 10'(NUM_SPI)};

    rsp_state_e  state_q, state_d;
    logic        err_q;
    logic [31:0] rdata_q;
    logic [31:0] rd_word;
    logic        rd_acc;

    assign rd_acc = acc_i && !wr_i;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:    state_d = rd_acc ? ST_RD_RESP : ST_IDLE;
            ST_RD_RESP: state_d = rd_acc ? ST_RD_RESP : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (addr_i == ADDR_W'(OFS_DESC))     rd_word = DESC_WORD;
        else if (addr_i == ADDR_W'(OFS_ERR)) rd_word = {31'd0, err_q};
        else                                 rd_word = 32'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= 32'd0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rd_acc ? rd_word : 32'd0;
            err_q   <= err_q | db_miss_i;
        end
    end

    always_comb begin
        rsp_valid_o = (state_q == ST_RD_RESP);
        rsp_rdata_o = rdata_q;
    end

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R7
    rsp_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(acc_i && !wr_i));

    // R1
    desc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(addr_i == ADDR_W'(OFS_DESC))) |-> (rsp_rdata_o == DESC_WORD));

    // R5
    doorbell_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(addr_i == ADDR_W'(OFS_DOORBELL))) |-> (rsp_rdata_o == 32'd0));
endmodule

// File: rtl/msg_doorbell_frame.sv
module msg_doorbell_frame
    import msgdb_pkg::*;
#(
    parameter int unsigned BASE_SPI = 64,
    parameter int unsigned NUM_SPI  = 16,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_SPI-1:0] irq_pulse
);
    localparam int unsigned LINE_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;

    logic              acc;
    logic              db_wr;
    logic              db_hit;
    logic              db_miss;
    logic [LINE_W-1:0] db_line;

    assign req_ready = 1'b1;
    assign acc       = req_valid && req_ready;
    assign db_wr     = acc && req_write && (req_addr == ADDR_W'(OFS_DOORBELL));

    msgdb_decode #(.BASE_SPI(BASE_SPI), .NUM_SPI(NUM_SPI), .LINE_W(LINE_W)) u_decode (
        .db_wr_i (db_wr),
        .id_i    (req_wdata),
        .hit_o   (db_hit),
        .miss_o  (db_miss),
        .line_o  (db_line)
    );

    msgdb_pulse #(.NUM_SPI(NUM_SPI), .LINE_W(LINE_W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (db_hit),
        .line_i  (db_line),
        .pulse_o (irq_pulse)
    );

    msgdb_regs #(.BASE_SPI(BASE_SPI), .NUM_SPI(NUM_SPI), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_i       (acc),
        .wr_i        (req_write),
        .addr_i      (req_addr),
        .db_miss_i   (db_miss),
        .rsp_valid_o (rsp_valid),
        .rsp_rdata_o (rsp_rdata)
    );

    // R4
    no_pulse_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_miss |=> (irq_pulse == '0));

    // R6
    desc_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && (req_addr == ADDR_W'(OFS_DESC))) |=> (irq_pulse == '0));

    // R7
    always_comb begin
        ready_high_chk: assert (req_ready == 1'b1);
    end
endmodule

// File: tb/msg_doorbell_frame_tb_top.sv
`timescale 1ns/1ps
module msg_doorbell_frame_tb_top;
    localparam int unsigned NUM = 16;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [15:0] exp_pulse;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h008, 32'd0,          16'h0000, 32'h0040_0010}, // R1 descriptor
        '{1'b0, 12'h010, 32'd0,          16'h0000, 32'h0000_0000}, // R8 error clear
        '{1'b1, 12'h040, 32'd96,         16'h0001, 32'h0},         // R2 low end
        '{1'b1, 12'h040, 32'd111,        16'h8000, 32'h0},         // R2 high end
        '{1'b0, 12'h010, 32'd0,          16'h0000, 32'h0000_0000}, // R4 no error yet
        '{1'b1, 12'h040, 32'd95,         16'h0000, 32'h0},         // R4 below
        '{1'b0, 12'h010, 32'd0,          16'h0000, 32'h0000_0001}, // R4 error set
        '{1'b1, 12'h040, 32'd112,        16'h0000, 32'h0},         // R4 above
        '{1'b1, 12'h040, 32'h0001_0060,  16'h0000, 32'h0},         // R4 upper bits
        '{1'b0, 12'h040, 32'd0,          16'h0000, 32'h0000_0000}, // R5 doorbell read
        '{1'b1, 12'h008, 32'hFFFF_FFFF,  16'h0000, 32'h0},         // R6 desc write
        '{1'b0, 12'h008, 32'd0,          16'h0000, 32'h0040_0010}, // R6 unchanged
        '{1'b1, 12'h040, 32'd100,        16'h0010, 32'h0},         // R3 first
        '{1'b1, 12'h040, 32'd101,        16'h0020, 32'h0},         // R3 second
        '{1'b0, 12'h000, 32'd0,          16'h0000, 32'h0000_0000}, // R5 unmapped
        '{1'b0, 12'h010, 32'd0,          16'h0000, 32'h0000_0001}  // R4 still set
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NUM-1:0]  irq_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    msg_doorbell_frame dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_pulse(irq_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [11:0] a, input logic [31:0] d);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 pulse in reset", 32'(irq_pulse), 32'd0);
        check("R8 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 ready", 32'(req_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].wr, VECS[i].addr, VECS[i].data);
            @(negedge clk);
            check($sformatf("R2 pulse vec %0d", i), 32'(irq_pulse), 32'(VECS[i].exp_pulse));
            check($sformatf("R7 rsp_valid vec %0d", i), 32'(rsp_valid), 32'(!VECS[i].wr));
            if (!VECS[i].wr)
                check($sformatf("R1 rdata vec %0d", i), rsp_rdata, VECS[i].exp_rd);
        end
        drive(1'b0, 1'b0, 12'h0, 32'd0);

        // R2 pulse width: exactly one cycle
        @(negedge clk);
        drive(1'b1, 1'b1, 12'h040, 32'd97);
        @(negedge clk);
        drive(1'b0, 1'b0, 12'h0, 32'd0);
        check("R2 pulse line1", 32'(irq_pulse), 32'h0002);
        @(negedge clk);
        check("R2 pulse gone", 32'(irq_pulse), 32'd0);
        check("R7 no rsp after write", 32'(rsp_valid), 32'd0);

        // R3 same line twice in a row
        drive(1'b1, 1'b1, 12'h040, 32'd103);
        @(negedge clk);
        check("R3 repeat first", 32'(irq_pulse), 32'h0080);
        @(negedge clk);
        drive(1'b0, 1'b0, 12'h0, 32'd0);
        check("R3 repeat second", 32'(irq_pulse), 32'h0080);
        @(negedge clk);
        check("R3 repeat end", 32'(irq_pulse), 32'd0);

        // R8 reset clears sticky error
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 12'h010, 32'd0);
        @(negedge clk);
        drive(1'b0, 1'b0, 12'h0, 32'd0);
        check("R8 error after reset", rsp_rdata, 32'd0);
        check("R8 rsp after reset read", 32'(rsp_valid), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule